// File: doc/BRIEF.md
# Escape-byte run-length expander

This block turns a compressed byte stream into a memory image of up to 64 KiB. Software, or a loader in front of it, pulses `start` together with the number of compressed bytes in the block. It then feeds those bytes over a valid/ready input. The block emits the expanded bytes over a valid/ready output. Each output byte carries a 16-bit write address, so the output can be sent straight into a RAM write port.

One byte value, 0xE5, acts as an escape. An escape followed by a nonzero count and a value stands for that value repeated count times. An escape followed by a zero stands for one literal 0xE5. Every other byte passes through once.

A block whose length equals the full image size (65536 bytes) is treated as raw data and copied without decoding. Output beyond the image size is dropped and flagged. A block that ends in the middle of an escape sequence is flagged as truncated.

Top module: `rle_expand`

## Requirements
- R1: While reset is held and in the cycle after it, `out_valid`, `in_ready`, `done`, `err_ovf` and `err_trunc` are all 0.
- R2: In a compressed block (length not 65536), any input byte other than 0xE5 is emitted exactly once, with the same value.
- R3: In a compressed block, the three bytes 0xE5, N (1 to 255), V are emitted as N copies of V.
- R4: In a compressed block, the two bytes 0xE5, 0x00 are emitted as a single 0xE5.
- R5: The first output byte after `start` has address 0. Each later output byte has the previous address plus one.
- R6: When `blk_len` is 65536, every input byte, 0xE5 included, is emitted once and unchanged, in order.
- R7: At most 65536 bytes are emitted per block. Any byte the stream asks for beyond that is not emitted, and `err_ovf` is set. `err_ovf` stays set until the next `start`.
- R8: If the block ends right after an escape byte, or right after the count byte of a run, `err_trunc` is set and `done` rises.
- R9: While a run still has more than its last byte to emit, `in_ready` is 0. The next input byte is accepted in the same cycle as the final byte of a run. With both sides always ready, a stream of literals flows at one byte per cycle.
- R10: `done` rises once all `blk_len` bytes have been accepted and the last output byte has left. While `done` is high, `in_ready` and `out_valid` are 0. A length of 0 gives `done` with no output.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new block; loads `blk_len` and clears address and errors |
| blk_len | input | 17 | Number of compressed input bytes in the block (0 to 65536) |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink takes the output byte this cycle |
| out_data | output | 8 | Expanded byte |
| out_addr | output | 16 | Image address of the expanded byte |
| done | output | 1 | Block fully consumed and emitted |
| err_ovf | output | 1 | Sticky: the output tried to exceed 65536 bytes |
| err_trunc | output | 1 | The block ended inside an escape sequence |

## Verification
Two functions meet in one cycle: the last byte of a run leaves the output, and the next compressed byte is taken at the input. This is provoked with a directed run followed by a literal, both sides held ready. The cycle in which the literal is accepted must equal the cycle in which the fifth run byte fires, and the literal must come out one cycle later. A second meeting happens at the image limit: the run that crosses 65536 bytes is cut off while the next escape waits at the input. The check is that exactly 65536 bytes come out, the last one at address 65535, and that the overflow flag rises without losing the end-of-block `done`. Random blocks with random valid and ready patterns confirm that input is never taken while a multi-byte run is held back by the sink.

// File: rtl/rle_pkg.sv
package rle_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PLAIN,
        PH_ESC,
        PH_CNT,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic              load;
        logic [BYTE_W-1:0] value;
        logic [BYTE_W-1:0] count;
    } run_req_t;

    function automatic logic is_raw_len(input logic [31:0] len, input int unsigned aw);
        return len == (32'd1 << aw);
    endfunction

endpackage

// File: rtl/rle_parse.sv
module rle_parse
    import rle_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [7:0]  ESC    = 8'hE5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W:0]   blk_len,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    input  logic              run_idle,
    input  logic              run_last,
    output run_req_t          req,
    output logic              done,
    output logic              err_trunc
);

    localparam int unsigned LEN_W = ADDR_W + 1;

    phase_t            phase_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  taken_q;
    logic              raw_q;
    logic [BYTE_W-1:0] cnt_q;
    logic              trunc_q;

    logic active;
    logic more;
    logic acc;

    assign active   = (phase_q == PH_PLAIN) || (phase_q == PH_ESC) || (phase_q == PH_CNT);
    assign more     = (taken_q != len_q);
    assign in_ready = active && more && (run_idle || run_last);
    assign acc      = in_valid && in_ready;

    always_comb begin
        req = '0;
        if (acc) begin
            if (raw_q) begin
                req = '{load: 1'b1, value: in_data, count: BYTE_W'(1)};
            end else begin
                case (phase_q)
                    PH_PLAIN: if (in_data != ESC)
                                  req = '{load: 1'b1, value: in_data, count: BYTE_W'(1)};
                    PH_ESC:   if (in_data == '0)
                                  req = '{load: 1'b1, value: ESC, count: BYTE_W'(1)};
                    PH_CNT:   req = '{load: 1'b1, value: in_data, count: cnt_q};
                    default:  req = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            len_q   <= '0;
            taken_q <= '0;
            raw_q   <= 1'b0;
            cnt_q   <= '0;
            trunc_q <= 1'b0;
        end else if (start) begin
            phase_q <= PH_PLAIN;
            len_q   <= blk_len;
            taken_q <= '0;
            raw_q   <= is_raw_len(32'(blk_len), ADDR_W);
            cnt_q   <= '0;
            trunc_q <= 1'b0;
        end else if (active && !more) begin
            if (phase_q == PH_ESC || phase_q == PH_CNT) begin
                trunc_q <= 1'b1;
                phase_q <= PH_DONE;
            end else if (run_idle) begin
                phase_q <= PH_DONE;
            end
        end else if (acc) begin
            taken_q <= taken_q + 1'b1;
            if (!raw_q) begin
                case (phase_q)
                    PH_PLAIN: if (in_data == ESC) phase_q <= PH_ESC;
                    PH_ESC: begin
                        cnt_q   <= in_data;
                        phase_q <= (in_data == '0) ? PH_PLAIN : PH_CNT;
                    end
                    PH_CNT:   phase_q <= PH_PLAIN;
                    default:  phase_q <= phase_q;
                endcase
            end
        end
    end

    assign done      = (phase_q == PH_DONE);
    assign err_trunc = trunc_q;

endmodule

// File: rtl/rle_run.sv
module rle_run
    import rle_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  run_req_t          req,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic              run_idle,
    output logic              run_last,
    output logic              err_ovf
);

    logic [BYTE_W-1:0] rem_q;
    logic [BYTE_W-1:0] val_q;
    logic [ADDR_W:0]   emit_q;
    logic              ovf_q;

    logic full;
    logic fire;
    logic drop;

    assign full      = emit_q[ADDR_W];
    assign out_valid = (rem_q != '0) && !full;
    assign fire      = out_valid && out_ready;
    assign drop      = (rem_q != '0) && full;
    assign run_idle  = (rem_q == '0);
    assign run_last  = (rem_q == BYTE_W'(1)) && fire;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            rem_q  <= '0;
            val_q  <= '0;
            emit_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (req.load) begin
                rem_q <= req.count;
                val_q <= req.value;
            end else if (fire) begin
                rem_q <= rem_q - 1'b1;
            end else if (drop) begin
                rem_q <= '0;
            end
            if (fire) emit_q <= emit_q + 1'b1;
            if (drop) ovf_q  <= 1'b1;
        end
    end

    assign out_data = val_q;
    assign out_addr = emit_q[ADDR_W-1:0];
    assign err_ovf  = ovf_q;

endmodule

// File: rtl/rle_expand.sv
module rle_expand
    import rle_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [7:0]  ESC    = 8'hE5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W:0]   blk_len,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic              done,
    output logic              err_ovf,
    output logic              err_trunc
);

    run_req_t req;
    logic     run_idle;
    logic     run_last;

    rle_parse #(.ADDR_W(ADDR_W), .ESC(ESC)) u_parse (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .blk_len   (blk_len),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .run_idle  (run_idle),
        .run_last  (run_last),
        .req       (req),
        .done      (done),
        .err_trunc (err_trunc)
    );

    rle_run #(.ADDR_W(ADDR_W)) u_run (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req       (req),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_addr  (out_addr),
        .run_idle  (run_idle),
        .run_last  (run_last),
        .err_ovf   (err_ovf)
    );

endmodule

// File: rtl/rle_expand_chk.sv
module rle_expand_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic [ADDR_W-1:0] out_addr,
    input logic              done,
    input logic              err_ovf,
    input logic              err_trunc
);

    logic [ADDR_W:0] fired_q;

    always_ff @(posedge clk) begin
        if (rst || start) fired_q <= '0;
        else if (out_valid && out_ready) fired_q <= fired_q + 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !in_ready && !done && !err_ovf && !err_trunc));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst || start)
        (out_valid && out_ready) |=> (out_addr == ADDR_W'($past(out_addr) + 1'b1)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst || start)
        (out_valid && out_ready) |-> !fired_q[ADDR_W]);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err_ovf && !start) |=> err_ovf);

    assert_trunc_done_R8: assert property (@(posedge clk) disable iff (rst || start)
        err_trunc |-> done);

    assert_stall_R9: assert property (@(posedge clk) disable iff (rst || start)
        (in_ready && out_valid) |-> out_ready);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst || start)
        done |-> (!in_ready && !out_valid));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst || start)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)));

endmodule

bind rle_expand rle_expand_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_addr  (out_addr),
    .done      (done),
    .err_ovf   (err_ovf),
    .err_trunc (err_trunc)
);

// File: tb/rle_expand_tb.sv
`timescale 1ns/1ps
module rle_expand_tb;

    localparam int AW    = 16;
    localparam int IMG   = 1 << AW;
    localparam int LIMIT = 80000;

    logic          clk = 1'b0;
    logic          rst;
    logic          start = 1'b0;
    logic [AW:0]   blk_len = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;
    logic [AW-1:0] out_addr;
    logic          done;
    logic          err_ovf;
    logic          err_trunc;

    always #5 clk = ~clk;

    rle_expand u_dut (
        .clk(clk), .rst(rst), .start(start), .blk_len(blk_len),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_addr(out_addr), .done(done), .err_ovf(err_ovf), .err_trunc(err_trunc)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [7:0] stim[$];
    logic [7:0] expq[$];
    int acc_cyc[$];
    int out_cyc[$];
    bit exp_ovf, exp_trunc;
    int got_k, got_idx, mism, hold_bad, stall_bad, used_cyc;
    int first_bad_act, first_bad_exp;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic put(input logic [7:0] b);
        if (expq.size() >= IMG) exp_ovf = 1;
        else expq.push_back(b);
    endtask

    task automatic build_exp(input bit raw);
        int i = 0;
        int n = stim.size();
        expq = {}; exp_ovf = 0; exp_trunc = 0;
        while (i < n) begin
            if (raw || stim[i] != 8'hE5) begin
                put(stim[i]); i++;
            end else if (i + 1 >= n) begin
                exp_trunc = 1; i = n;
            end else if (stim[i+1] == 8'h00) begin
                put(8'hE5); i += 2;
            end else if (i + 2 >= n) begin
                exp_trunc = 1; i = n;
            end else begin
                for (int r = 0; r < int'(stim[i+1]); r++) put(stim[i+2]);
                i += 3;
            end
        end
    endtask

    task automatic run_block(input int vpct, input int rpct);
        int n = stim.size();
        int idx = 0, k = 0, cyc = 0;
        bit prev_hold = 0;
        logic [7:0] pd = '0;
        logic [AW-1:0] pa = '0;
        mism = 0; hold_bad = 0; stall_bad = 0;
        first_bad_act = 0; first_bad_exp = 0;
        acc_cyc = {}; out_cyc = {};
        @(negedge clk);
        start = 1; blk_len = (AW+1)'(n); in_valid = 0; out_ready = 0;
        @(negedge clk);
        start = 0;
        while (cyc < LIMIT) begin
            in_valid  = (idx < n) && (($urandom % 100) < vpct);
            in_data   = (idx < n) ? stim[idx] : 8'h00;
            out_ready = (($urandom % 100) < rpct);
            #1;
            if (prev_hold && (!out_valid || out_data != pd || out_addr != pa)) hold_bad++;
            prev_hold = out_valid && !out_ready;
            pd = out_data; pa = out_addr;
            if (in_ready && out_valid && !out_ready) stall_bad++;
            if (in_valid && in_ready) begin acc_cyc.push_back(cyc); idx++; end
            if (out_valid && out_ready) begin
                if (k >= expq.size() || out_data != expq[k] || out_addr != AW'(k)) begin
                    if (mism == 0) begin
                        first_bad_act = int'(out_data);
                        first_bad_exp = (k < expq.size()) ? int'(expq[k]) : -1;
                    end
                    mism++;
                end
                out_cyc.push_back(cyc);
                k++;
            end
            if (done) break;
            cyc++;
            @(negedge clk);
        end
        got_k = k; got_idx = idx; used_cyc = cyc;
        in_valid = 0;
    endtask

    task automatic check_block(input string tag);
        chk(mism == 0, {tag, " data/addr"}, first_bad_act, first_bad_exp);
        chk(got_k == expq.size(), {tag, " count"}, got_k, expq.size());
        chk(err_ovf == exp_ovf, {tag, " R7 ovf flag"}, err_ovf, exp_ovf);
        chk(err_trunc == exp_trunc, {tag, " R8 trunc flag"}, err_trunc, exp_trunc);
        chk(done && !in_ready && !out_valid, {tag, " R10 done"}, done, 1);
        chk(got_idx == stim.size(), {tag, " R10 consumed"}, got_idx, stim.size());
        chk(hold_bad == 0, {tag, " R11 hold"}, hold_bad, 0);
        chk(stall_bad == 0, {tag, " R9 stall"}, stall_bad, 0);
    endtask

    task automatic gen_random(input int tokens);
        stim = {};
        for (int t = 0; t < tokens; t++) begin
            int sel = $urandom % 10;
            if (sel < 5) begin
                logic [7:0] b = 8'($urandom);
                if (b == 8'hE5) b = 8'h5E;
                stim.push_back(b);
            end else if (sel < 7) begin
                stim.push_back(8'hE5); stim.push_back(8'h00);
            end else begin
                stim.push_back(8'hE5);
                stim.push_back(8'(1 + ($urandom % 12)));
                stim.push_back((($urandom % 4) == 0) ? 8'hE5 : 8'($urandom));
            end
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1;
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid && !in_ready && !done && !err_ovf && !err_trunc, "R1 reset outputs", out_valid, 0);
        @(negedge clk);
        rst = 0;
        #1;
        chk(!out_valid && !in_ready && !done, "R1 after reset", in_ready, 0);

        // R2 literals, full throughput (R9)
        stim = {};
        for (int i = 0; i < 20; i++) stim.push_back(8'(i * 7 + 1));
        build_exp(0); run_block(100, 100); check_block("R2 literals");
        chk(out_cyc.size() == 20 && out_cyc[19] == 20, "R9 literal rate", out_cyc.size() > 0 ? out_cyc[out_cyc.size()-1] : -1, 20);

        // R3 runs incl. count 1 and 255
        stim = {8'hE5, 8'h04, 8'h3C, 8'hE5, 8'h01, 8'h99, 8'hE5, 8'hFF, 8'hE5, 8'h11};
        build_exp(0); run_block(100, 100); check_block("R3 runs");
        chk(got_k == 261, "R3 run length", got_k, 261);

        // R4 literal escape, R5 addresses
        stim = {8'hE5, 8'h00, 8'h42, 8'hE5, 8'h00, 8'hE5, 8'h00};
        build_exp(0); run_block(100, 100); check_block("R4 esc literal R5");

        // R9 overlap: last run byte and next input in same cycle
        stim = {8'hE5, 8'h05, 8'h77, 8'h12};
        build_exp(0); run_block(100, 100); check_block("R9 overlap");
        chk(acc_cyc.size() == 4 && out_cyc.size() == 6 && acc_cyc[3] == out_cyc[4],
            "R9 accept at final run byte", acc_cyc.size() == 4 ? acc_cyc[3] : -1, out_cyc.size() > 4 ? out_cyc[4] : -1);
        chk(out_cyc.size() == 6 && out_cyc[5] == out_cyc[4] + 1, "R9 next literal cycle",
            out_cyc.size() == 6 ? out_cyc[5] : -1, out_cyc.size() == 6 ? out_cyc[4] + 1 : -1);

        // R8 truncation after escape and after count
        stim = {8'h10, 8'hE5};
        build_exp(0); run_block(100, 100); check_block("R8 end after escape");
        chk(err_trunc == 1, "R8 trunc esc", err_trunc, 1);
        stim = {8'h10, 8'hE5, 8'h03};
        build_exp(0); run_block(80, 60); check_block("R8 end after count");
        chk(err_trunc == 1, "R8 trunc count", err_trunc, 1);

        // R10 empty block
        stim = {};
        build_exp(0); run_block(100, 100); check_block("R10 empty");
        chk(got_k == 0, "R10 empty no output", got_k, 0);

        // random blocks with backpressure R2 R3 R4 R5 R11
        for (int b = 0; b < 20; b++) begin
            gen_random(60 + ($urandom % 40));
            build_exp(0);
            run_block(40 + ($urandom % 60), 30 + ($urandom % 70));
            check_block("R3 random block");
        end

        // R6 raw block of full image size
        stim = {};
        for (int i = 0; i < IMG; i++) stim.push_back(((i % 97) == 0) ? 8'hE5 : 8'($urandom));
        build_exp(1); run_block(100, 100); check_block("R6 raw");
        chk(got_k == IMG && err_ovf == 0, "R6 raw length", got_k, IMG);

        // R7 overflow: 65535 + 3 bytes requested
        stim = {};
        for (int i = 0; i < 257; i++) begin
            stim.push_back(8'hE5); stim.push_back(8'hFF); stim.push_back(8'(i));
        end
        stim.push_back(8'hE5); stim.push_back(8'h03); stim.push_back(8'hAB);
        build_exp(0); run_block(100, 100); check_block("R7 overflow");
        chk(got_k == IMG && err_ovf == 1, "R7 capped", got_k, IMG);

        // R7 flags clear on next start
        stim = {8'h01, 8'h02};
        build_exp(0); run_block(100, 100); check_block("R7 restart clears");
        chk(err_ovf == 0, "R7 ovf cleared", err_ovf, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule